// File: doc/BRIEF.md
# Center-Aligned PWM Channel

This block is one 8-bit pulse-width channel. It sits behind an external prescaler that supplies a one-cycle clock-enable pulse (`tick`), and it drives a single waveform pin. Software-side logic writes a period value and a duty value through plain write strobes. The channel produces either an edge-aligned waveform, where the counter only counts up, or a center-aligned waveform, where the counter counts up to the period and back down. The center-aligned form gives pulses that are symmetric about the middle of each period.

Period and duty writes made while the channel runs are held in buffer registers. They take effect only when the counter comes back to zero, so a period never mixes old and new settings. While the channel is disabled, writes take effect at once, the counter rests at zero and the pin shows the inactive level. A polarity input chooses which level is the active one. The alignment mode should be chosen before the channel is enabled.

Top module: `pwm_ca_channel`

## Requirements
- R1: A synchronous active-high reset clears the counter to 0 with direction up, clears both buffered and active period and duty to 0, and drives `pwm_out` to 0.
- R2: While `chan_en` is 0, the counter is held at 0 with direction up, and from the next clock `pwm_out` equals the inverse of `pol` (the idle level).
- R3: A period or duty write (strobe high for one clock) made while `chan_en` is 0 updates both the buffer and the active register, so it applies from the first tick after enable.
- R4: The counter changes only on clocks where `chan_en` and `tick` are both 1. On all other clocks the output holds the level set by the current counter state.
- R5: With `center_mode` = 0, the counter counts 0,1,…,P-1 and wraps to 0, so the period is P ticks. The output is `pol` while count < D and `~pol` otherwise, where P and D are the active period and duty.
- R6: With `center_mode` = 1, the counter counts up through 0…P-1, then reaches P and counts down through P…1, and then returns to 0 and counts up again. The period is 2·P ticks.
- R7: With `center_mode` = 1, the output is `pol` when counting up with count < D, or when counting down with count ≤ D. This gives 2·min(D,P) active ticks per period, centered in the period.
- R8: A write made while enabled changes only the buffer. The active period and duty load from the buffer only when the counter returns to 0: at the wrap in edge-aligned mode, or at the down-count step from 1 to 0 in center-aligned mode.
- R9: D = 0 gives a constant `~pol` and D ≥ P gives a constant `pol` for the whole period, with no transitions.
- R10: `pwm_out` is registered: after each clock edge it shows the level for the counter state that was present at that edge, so it lags the state by one clock.
- R11: With an active period of 0 and the channel enabled, the counter stays at 0 and reloads on every tick, so the output is constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable, one clock wide |
| chan_en | input | 1 | Channel enable |
| center_mode | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| pol | input | 1 | Active output level |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 8 | Period write value |
| dty_wr | input | 1 | Duty write strobe |
| dty_wdata | input | 8 | Duty write value |
| pwm_out | output | 1 | PWM waveform |

## Verification
Any wrong counter value or direction reaches `pwm_out` on the very next clock as the wrong level. Over one full period it shows up as a wrong active-tick count, so the bench measures active time and transitions across whole periods for many mode, polarity, period, duty and tick-rate mixes. A buffer that loads early would change the level inside the period in which the write occurred, so a cycle-exact test writes a new duty during a down-count and checks the levels before and after the next return to zero.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cval_t;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    typedef struct packed {
        cval_t cnt;
        dir_e  dir;
    } cstate_t;

    typedef struct packed {
        cstate_t st;
        logic    load;
    } cstep_t;

    // One counter advance for a given active period and alignment.
    function automatic cstep_t cnt_step(cstate_t cur, cval_t per, logic center);
        cstep_t           r;
        logic [CNT_W:0]   inc;
        inc    = {1'b0, cur.cnt} + 1'b1;
        r.st   = cur;
        r.load = 1'b0;
        if (per == '0) begin
            r.st.cnt = '0;
            r.st.dir = DIR_UP;
            r.load   = 1'b1;
        end else if (!center) begin
            r.st.dir = DIR_UP;
            if (inc >= {1'b0, per}) begin
                r.st.cnt = '0;
                r.load   = 1'b1;
            end else begin
                r.st.cnt = inc[CNT_W-1:0];
            end
        end else if (cur.dir == DIR_UP) begin
            if (inc >= {1'b0, per}) begin
                r.st.cnt = per;
                r.st.dir = DIR_DN;
            end else begin
                r.st.cnt = inc[CNT_W-1:0];
            end
        end else begin
            if (cur.cnt <= cval_t'(1)) begin
                r.st.cnt = '0;
                r.st.dir = DIR_UP;
                r.load   = 1'b1;
            end else begin
                r.st.cnt = cur.cnt - 1'b1;
            end
        end
        return r;
    endfunction

    // True while the waveform is in its active part.
    function automatic logic in_active(cstate_t cur, cval_t dty);
        if (cur.dir == DIR_UP) return (cur.cnt < dty);
        else                   return (cur.cnt <= dty);
    endfunction

endpackage

// File: rtl/pwm_dbl_reg.sv
module pwm_dbl_reg
    import pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  load,
    input  logic  wr,
    input  cval_t wdata,
    output cval_t act
);
    cval_t buf_q;
    cval_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr) buf_q <= wdata;
            if (!en) begin
                if (wr) act_q <= wdata;
            end else if (load) begin
                act_q <= buf_q;
            end
        end
    end

    assign act = act_q;

    // R8: while running, active value moves only at a reload point
    p_buffered_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && !$past(load)) |-> $stable(act_q))
        else $error("active register changed outside reload");

    // R3: while idle, a write lands in the active register directly
    p_direct_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en) && $past(wr)) |-> (act_q == $past(wdata)))
        else $error("idle write not applied");

endmodule

// File: rtl/pwm_updown_cnt.sv
module pwm_updown_cnt
    import pwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    tick,
    input  logic    center,
    input  cval_t   per_act,
    output cstate_t st,
    output logic    load
);
    cstate_t st_q;
    cstep_t  step;

    always_comb begin
        step = cnt_step(st_q, per_act, center);
    end

    assign load = en && tick && step.load;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.dir <= DIR_UP;
        end else if (!en) begin
            st_q.cnt <= '0;
            st_q.dir <= DIR_UP;
        end else if (tick) begin
            st_q <= step.st;
        end
    end

    assign st = st_q;

    // R4: no movement without a tick
    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(st_q))
        else $error("counter moved without tick");

    // R2: disabled channel parks at zero counting up
    p_idle_park_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q.cnt == '0 && st_q.dir == DIR_UP))
        else $error("counter not parked");

    // R6: count never exceeds the active period
    p_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (en && per_act != '0) |-> (st_q.cnt <= per_act))
        else $error("counter above period");

    // R6: a down-count never sits at zero
    p_down_nz_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.dir == DIR_DN) |-> (st_q.cnt != '0))
        else $error("down-count at zero");

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    pol,
    input  cstate_t st,
    input  cval_t   dty_act,
    output logic    pwm_out
);
    logic out_q;
    logic lvl;

    always_comb begin
        if (!en) lvl = ~pol;
        else     lvl = in_active(st, dty_act) ? pol : ~pol;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= lvl;
    end

    assign pwm_out = out_q;

    // R2: idle level follows polarity
    p_idle_lvl_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |-> (out_q == !$past(pol)))
        else $error("idle level wrong");

    // R9: zero duty never shows the active level
    p_zero_duty_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && $past(dty_act) == '0) |-> (out_q == !$past(pol)))
        else $error("zero duty produced a pulse");

endmodule

// File: rtl/pwm_ca_channel.sv
module pwm_ca_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             chan_en,
    input  logic             center_mode,
    input  logic             pol,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             dty_wr,
    input  logic [CNT_W-1:0] dty_wdata,
    output logic             pwm_out
);
    localparam int NREG = 2;

    cval_t   per_act;
    cval_t   dty_act;
    cstate_t st;
    logic    load;

    logic  reg_wr [NREG];
    cval_t reg_wd [NREG];
    cval_t reg_q  [NREG];

    assign reg_wr[0] = per_wr;
    assign reg_wd[0] = per_wdata;
    assign reg_wr[1] = dty_wr;
    assign reg_wd[1] = dty_wdata;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            pwm_dbl_reg u_reg (
                .clk   (clk),
                .rst   (rst),
                .en    (chan_en),
                .load  (load),
                .wr    (reg_wr[i]),
                .wdata (reg_wd[i]),
                .act   (reg_q[i])
            );
        end
    endgenerate

    assign per_act = reg_q[0];
    assign dty_act = reg_q[1];

    pwm_updown_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (chan_en),
        .tick    (tick),
        .center  (center_mode),
        .per_act (per_act),
        .st      (st),
        .load    (load)
    );

    pwm_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .en      (chan_en),
        .pol     (pol),
        .st      (st),
        .dty_act (dty_act),
        .pwm_out (pwm_out)
    );

    // R1: reset leaves the pin low
    p_reset_low_r1: assert property (@(posedge clk)
        $past(rst) |-> (pwm_out == 1'b0))
        else $error("pin not low after reset");

endmodule

// File: tb/sim_pwm_ca_channel.sv
`timescale 1ns/1ps
module sim_pwm_ca_channel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       chan_en = 1'b0;
    logic       center_mode = 1'b0;
    logic       pol = 1'b0;
    logic       per_wr = 1'b0;
    logic [7:0] per_wdata = '0;
    logic       dty_wr = 1'b0;
    logic [7:0] dty_wdata = '0;
    logic       pwm_out;

    int n_chk = 0;
    int n_err = 0;
    int tick_div = 1;
    int tcnt = 0;

    always #2.5 clk = ~clk;

    pwm_ca_channel u0 (
        .clk(clk), .rst(rst), .tick(tick), .chan_en(chan_en),
        .center_mode(center_mode), .pol(pol),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .dty_wr(dty_wr), .dty_wdata(dty_wdata),
        .pwm_out(pwm_out)
    );

    always @(negedge clk) begin
        if (tick_div == 0) begin
            tick = 1'b0;
        end else begin
            tick = (tcnt == 0);
            tcnt = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
        end
    end

    typedef struct packed {
        logic        center;
        logic        pl;
        logic [7:0]  per;
        logic [7:0]  dty;
        logic [3:0]  div;
        logic [15:0] per_clk;
        logic [15:0] act_clk;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 8'd10,  8'd3,   4'd1, 16'd10,  16'd3},   // R5
        '{1'b0, 1'b0, 8'd8,   8'd8,   4'd1, 16'd8,   16'd8},   // R5 R9 full
        '{1'b0, 1'b1, 8'd6,   8'd0,   4'd1, 16'd6,   16'd0},   // R9 zero
        '{1'b1, 1'b1, 8'd10,  8'd3,   4'd1, 16'd20,  16'd6},   // R6 R7
        '{1'b1, 1'b0, 8'd5,   8'd2,   4'd1, 16'd10,  16'd4},   // R7 pol 0
        '{1'b1, 1'b1, 8'd4,   8'd9,   4'd1, 16'd8,   16'd8},   // R9 above period
        '{1'b1, 1'b1, 8'd7,   8'd0,   4'd1, 16'd14,  16'd0},   // R9 zero
        '{1'b1, 1'b0, 8'd1,   8'd1,   4'd1, 16'd2,   16'd2},   // R6 smallest
        '{1'b1, 1'b1, 8'd255, 8'd128, 4'd1, 16'd510, 16'd256}, // R6 largest
        '{1'b1, 1'b1, 8'd6,   8'd2,   4'd2, 16'd24,  16'd8},   // R4 half rate
        '{1'b0, 1'b1, 8'd255, 8'd254, 4'd1, 16'd255, 16'd254}, // R5 largest
        '{1'b1, 1'b1, 8'd3,   8'd2,   4'd3, 16'd18,  16'd12}   // R4 third rate
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_per(input logic [7:0] v);
        per_wr = 1'b1; per_wdata = v; cyc(1); per_wr = 1'b0;
    endtask

    task automatic wr_dty(input logic [7:0] v);
        dty_wr = 1'b1; dty_wdata = v; cyc(1); dty_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        int hi;
        int tr;
        logic prev;
        // R1 reset
        cyc(3);
        chk("R1 out during reset", pwm_out, 0);
        rst = 1'b0;
        pol = 1'b0;
        cyc(1);
        chk("R2 idle level pol0", pwm_out, 1);
        pol = 1'b1;
        cyc(1);
        chk("R2 idle level pol1 (R10 one clock)", pwm_out, 0);

        // R1 cleared registers: period 0, duty 0 -> constant inactive
        center_mode = 1'b1;
        chan_en = 1'b1;
        cyc(6);
        chk("R1 cleared period/duty", pwm_out, 0);
        chan_en = 1'b0;
        cyc(1);

        // R11 zero period with nonzero duty -> constant active
        wr_dty(8'd5);
        chan_en = 1'b1;
        tr = 0; prev = 1'b0;
        cyc(1); prev = pwm_out;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (pwm_out !== prev) tr++;
            prev = pwm_out;
        end
        chk("R11 zero period level", pwm_out, 1);
        chk("R11 zero period transitions", tr, 0);
        chan_en = 1'b0;
        cyc(1);

        // R4 no tick: state frozen at zero
        tick_div = 0;
        wr_per(8'd4);
        wr_dty(8'd2);
        chan_en = 1'b1;
        cyc(12);
        chk("R4 frozen without tick", pwm_out, 1);
        cyc(5);
        chk("R4 still frozen", pwm_out, 1);
        chan_en = 1'b0;
        tick_div = 1;
        cyc(2);

        // Table walk: active time and transitions over two periods
        for (int v = 0; v < NV; v++) begin
            chan_en = 1'b0;
            center_mode = VECS[v].center;
            pol = VECS[v].pl;
            tick_div = int'(VECS[v].div);
            cyc(1);
            wr_per(VECS[v].per);
            wr_dty(VECS[v].dty);      // R3 idle writes apply at once
            chan_en = 1'b1;
            cyc(8 + int'(VECS[v].div));
            hi = 0; tr = 0; prev = pwm_out;
            for (int k = 0; k < 2 * int'(VECS[v].per_clk); k++) begin
                cyc(1);
                if (pwm_out === VECS[v].pl) hi++;
                if (pwm_out !== prev) tr++;
                prev = pwm_out;
            end
            chk($sformatf("R5/R7 R3 active time vec%0d", v), hi, 2 * int'(VECS[v].act_clk));
            if (VECS[v].act_clk == 0 || VECS[v].act_clk == VECS[v].per_clk)
                chk($sformatf("R9 no transitions vec%0d", v), tr, 0);
            else
                chk($sformatf("R7 two edges per period vec%0d", v), tr, 4);
        end
        chan_en = 1'b0;
        tick_div = 1;
        cyc(2);

        // R8 buffered duty in center mode, cycle exact (R10 latency)
        center_mode = 1'b1;
        pol = 1'b1;
        wr_per(8'd10);
        wr_dty(8'd3);
        cyc(1);
        chk("R2 idle before enable", pwm_out, 0);
        chan_en = 1'b1;
        cyc(1);
        chk("R10 first state shows at once", pwm_out, 1);
        cyc(10);
        chk("R7 down-count above duty", pwm_out, 0);
        dty_wr = 1'b1; dty_wdata = 8'd8;
        cyc(1);
        dty_wr = 1'b0;
        cyc(2);
        chk("R8 old duty kept cnt7 down", pwm_out, 0);
        cyc(3);
        chk("R8 old duty kept cnt4 down", pwm_out, 0);
        cyc(9);
        chk("R8 new duty after reload cnt5 up", pwm_out, 1);
        chan_en = 1'b0;
        cyc(1);
        chk("R2 idle after disable", pwm_out, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule